// File: doc/BRIEF.md
# Eight-bit ALU with Status Register

This block is the arithmetic and logic stage of a small eight-bit processor datapath. A request carries an operation code, operand A, and either operand B or an immediate value. The block computes the result in one combinational pass. It captures the result into an output register and updates an eight-bit status register on the same clock edge. The carry-in and the T bit used by an operation always come from the status register as it stands when the request is accepted. A chain of carry-dependent requests issued back to back therefore sees each predecessor's flags.

Each operation writes only its own subset of the status bits. The status layout, from bit 7 down to bit 0, is: interrupt enable I, user bit T, half-carry H, signed test S, overflow V, negative N, zero Z, carry C. Compares, flag set/clear and bit-store update status but flag their result as not to be written back. Both sides use valid/ready handshakes. A request is taken when `op_valid` and `op_ready` are both high. `op_ready` is high when the output register is empty or is being drained in the same cycle. A result stays on the output, unchanged, until `res_ready` is seen high.

Top module: `alu8_status`

## Requirements
- R1: After reset (`rst_n` low, synchronous) the status register reads 0x00, `res_valid` is low and `op_ready` is high.
- R2: A request is accepted on a rising edge with `op_valid` and `op_ready` both high, where `op_ready` = not `res_valid` or `res_ready`. The result, write-back flag and new status appear after that edge with `res_valid` high. While `res_valid` is high and `res_ready` is low, the output holds steady and status does not change.
- R3: Codes ADD=0 and ADC=1 (ADC also adds C) give A+B. C is the carry out of bit 7, H is the carry out of bit 3, and V is set when both operands have the same sign and the result's sign differs.
- R4: Codes SUB=2 and SBC=3 (SBC also subtracts C) give A-B. NEG=6 gives 0-A. C is the borrow out of bit 7, H is the borrow out of the low nibble, and V is set when the operands differ in sign and the result's sign differs from the minuend.
- R5: For SBC and CPC=5, Z becomes 1 only if the result is zero and Z was already 1; a nonzero result clears Z.
- R6: Compares CP=4 (like SUB) and CPC=5 (like SBC) update flags as their subtraction would. They present the difference with `res_wb` low; all other arithmetic, logic, shift, swap and bit-load codes raise `res_wb`.
- R7: AND=7, OR=8, XOR=9 clear V. INC=10 sets V when the result is 0x80, and DEC=11 sets V when the result is 0x7F. These codes update only Z, N, V and S, leaving C and H unchanged.
- R8: COM=12 returns the bitwise inverse of A, sets C to 1 and clears V.
- R9: LSL=13 shifts left with zero fill and LSR=14 shifts right with zero fill. ROL=15 moves C into bit 0, and ROR=16 moves C into bit 7. ASR=17 keeps bit 7. C takes the bit shifted out, V = N xor C, and H is unchanged.
- R10: Whenever an operation updates N and V, N is result bit 7, Z is set for a zero result (subject to R5), and S = N xor V.
- R11: SWAP=18 exchanges the nibbles of A and changes no status bit. Unused codes 23 to 31 return A with `res_wb` low and no status change.
- R12: FSET=19 sets and FCLR=20 clears the one status bit indexed by `sel`. Both return A with `res_wb` low.
- R13: TSTORE=21 copies bit `sel` of A into T (`res_wb` low), and TLOAD=22 returns A with bit `sel` replaced by T.
- R14: When `use_imm` is high, `imm` replaces `opnd_b` as operand B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Request present |
| op_ready | output | 1 | Request can be taken this cycle |
| op_code | input | 5 | Operation code |
| opnd_a | input | DW | Operand A |
| opnd_b | input | DW | Register operand B |
| imm | input | DW | Immediate operand B |
| use_imm | input | 1 | Select immediate as operand B |
| sel | input | SEL_W | Status bit index or operand bit index |
| res_valid | output | 1 | Result register holds a result |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | DW | Result value |
| res_wb | output | 1 | Result is meant to be written back |
| status | output | 8 | Status register I,T,H,S,V,N,Z,C (bit 7..0) |

## Verification
Two things can happen on the same edge: a result is drained, and a new request is accepted whose carry-in, Z or T depends on the status the previous request just wrote. The bench provokes this by keeping `res_ready` mostly high while issuing SBC, CPC, ROL, ROR and TLOAD directly after flag-changing operations. It also applies random back-pressure so that other requests stall behind a held result. Every result and status byte is compared against a bench model that carries its own copy of status from request to request. During each stall the held output is compared with the previous expected value.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [4:0] {
    OP_ADD    = 5'd0,
    OP_ADC    = 5'd1,
    OP_SUB    = 5'd2,
    OP_SBC    = 5'd3,
    OP_CP     = 5'd4,
    OP_CPC    = 5'd5,
    OP_NEG    = 5'd6,
    OP_AND    = 5'd7,
    OP_OR     = 5'd8,
    OP_XOR    = 5'd9,
    OP_INC    = 5'd10,
    OP_DEC    = 5'd11,
    OP_COM    = 5'd12,
    OP_LSL    = 5'd13,
    OP_LSR    = 5'd14,
    OP_ROL    = 5'd15,
    OP_ROR    = 5'd16,
    OP_ASR    = 5'd17,
    OP_SWAP   = 5'd18,
    OP_FSET   = 5'd19,
    OP_FCLR   = 5'd20,
    OP_TSTORE = 5'd21,
    OP_TLOAD  = 5'd22
  } alu_op_e;

  // status bit positions
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;
  localparam int FL_T = 6;
  localparam int FL_I = 7;
  localparam int STATUS_W = 8;

endpackage

// File: rtl/alu8_addsub.sv
// Shared adder/subtractor with carry/borrow, nibble carry and overflow.
module alu8_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output logic          cout,
  output logic          hcarry,
  output logic          ovf
);
  localparam int NIB = 4;

  logic [DW:0]  wide;
  logic [NIB:0] nib;

  always_comb begin
    if (sub) begin
      wide = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
      nib  = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, cin};
    end else begin
      wide = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
      nib  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
    end
  end

  assign sum    = wide[DW-1:0];
  assign cout   = wide[DW];
  assign hcarry = nib[NIB];
  assign ovf    = sub ? ((a[DW-1] != b[DW-1]) && (sum[DW-1] != a[DW-1]))
                      : ((a[DW-1] == b[DW-1]) && (sum[DW-1] != a[DW-1]));
endmodule

// File: rtl/alu8_unary.sv
// Logic ops, increment/decrement, complement, shifts, swap and bit load.
module alu8_unary
  import alu8_pkg::*;
#(
  parameter int DW    = 8,
  parameter int SEL_W = 3
) (
  input  alu_op_e          op,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  input  logic             cin,
  input  logic             tbit,
  input  logic [SEL_W-1:0] sel,
  output logic [DW-1:0]    res,
  output logic             cout,
  output logic             vout
);
  localparam int HALF = DW / 2;
  localparam logic [DW-1:0] MIN_NEG = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] MAX_POS = {1'b0, {(DW-1){1'b1}}};

  logic [DW-1:0] swapped;
  logic [DW-1:0] loaded;

  // nibble swap for even widths, half rotate otherwise
  generate
    if ((DW % 2) == 0) begin : g_even
      assign swapped = {a[HALF-1:0], a[DW-1:HALF]};
    end else begin : g_odd
      assign swapped = {a[HALF:0], a[DW-1:HALF+1]};
    end
  endgenerate

  always_comb begin
    loaded = a;
    loaded[sel] = tbit;
  end

  always_comb begin
    res  = a;
    cout = cin;
    vout = 1'b0;
    unique case (op)
      OP_AND:   res = a & b;
      OP_OR:    res = a | b;
      OP_XOR:   res = a ^ b;
      OP_INC: begin
        res  = a + 1'b1;
        vout = (res == MIN_NEG);
      end
      OP_DEC: begin
        res  = a - 1'b1;
        vout = (res == MAX_POS);
      end
      OP_COM: begin
        res  = ~a;
        cout = 1'b1;
      end
      OP_LSL: begin
        res  = {a[DW-2:0], 1'b0};
        cout = a[DW-1];
      end
      OP_ROL: begin
        res  = {a[DW-2:0], cin};
        cout = a[DW-1];
      end
      OP_LSR: begin
        res  = {1'b0, a[DW-1:1]};
        cout = a[0];
      end
      OP_ROR: begin
        res  = {cin, a[DW-1:1]};
        cout = a[0];
      end
      OP_ASR: begin
        res  = {a[DW-1], a[DW-1:1]};
        cout = a[0];
      end
      OP_SWAP:  res = swapped;
      OP_TLOAD: res = loaded;
      default:  res = a;
    endcase
    if (op inside {OP_LSL, OP_ROL, OP_LSR, OP_ROR, OP_ASR}) begin
      vout = res[DW-1] ^ cout;
    end
  end
endmodule

// File: rtl/alu8_flag_next.sv
// Chooses the result and builds the next status byte per operation.
module alu8_flag_next
  import alu8_pkg::*;
#(
  parameter int DW    = 8,
  parameter int SEL_W = 3
) (
  input  alu_op_e                op,
  input  logic [DW-1:0]          a,
  input  logic [SEL_W-1:0]       sel,
  input  logic [STATUS_W-1:0]    st,
  input  logic [DW-1:0]          ar_res,
  input  logic                   ar_c,
  input  logic                   ar_h,
  input  logic                   ar_v,
  input  logic [DW-1:0]          un_res,
  input  logic                   un_c,
  input  logic                   un_v,
  output logic [DW-1:0]          result,
  output logic                   wb,
  output logic                   nzv_upd,
  output logic [STATUS_W-1:0]    st_next
);
  localparam int FIDX_W = $clog2(STATUS_W);

  logic [FIDX_W-1:0] fidx;
  logic              z_chain;

  assign fidx = sel[FIDX_W-1:0];

  always_comb begin
    st_next = st;
    result  = a;
    wb      = 1'b1;
    nzv_upd = 1'b0;
    z_chain = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG: begin
        result        = ar_res;
        st_next[FL_C] = ar_c;
        st_next[FL_H] = ar_h;
        st_next[FL_V] = ar_v;
        nzv_upd       = 1'b1;
        z_chain       = (op == OP_SBC) || (op == OP_CPC);
        wb            = !((op == OP_CP) || (op == OP_CPC));
      end
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
        result        = un_res;
        st_next[FL_V] = un_v;
        nzv_upd       = 1'b1;
      end
      OP_COM, OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
        result        = un_res;
        st_next[FL_C] = un_c;
        st_next[FL_V] = un_v;
        nzv_upd       = 1'b1;
      end
      OP_SWAP, OP_TLOAD: result = un_res;
      OP_FSET: begin
        st_next[fidx] = 1'b1;
        wb            = 1'b0;
      end
      OP_FCLR: begin
        st_next[fidx] = 1'b0;
        wb            = 1'b0;
      end
      OP_TSTORE: begin
        st_next[FL_T] = a[sel];
        wb            = 1'b0;
      end
      default: wb = 1'b0;
    endcase
    if (nzv_upd) begin
      st_next[FL_N] = result[DW-1];
      st_next[FL_Z] = z_chain ? ((result == '0) && st[FL_Z]) : (result == '0);
      st_next[FL_S] = st_next[FL_N] ^ st_next[FL_V];
    end
  end
endmodule

// File: rtl/alu8_status.sv
// Top: handshake, operand select, result and status registers.
module alu8_status
  import alu8_pkg::*;
#(
  parameter int DW    = 8,
  parameter int SEL_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  output logic                op_ready,
  input  logic [4:0]          op_code,
  input  logic [DW-1:0]       opnd_a,
  input  logic [DW-1:0]       opnd_b,
  input  logic [DW-1:0]       imm,
  input  logic                use_imm,
  input  logic [SEL_W-1:0]    sel,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [DW-1:0]       res_data,
  output logic                res_wb,
  output logic [STATUS_W-1:0] status
);
  alu_op_e             op;
  logic [DW-1:0]       b_sel;
  logic [DW-1:0]       ar_a, ar_b, ar_res, un_res, nx_res;
  logic                ar_cin, ar_sub, ar_c, ar_h, ar_v, un_c, un_v;
  logic                nx_wb, nzv_upd, accept;
  logic [STATUS_W-1:0] st_next;

  assign op       = alu_op_e'(op_code);
  assign b_sel    = use_imm ? imm : opnd_b;
  assign op_ready = !res_valid || res_ready;
  assign accept   = op_valid && op_ready;

  // adder operand steering: NEG computes 0 - A
  always_comb begin
    ar_a   = opnd_a;
    ar_b   = b_sel;
    ar_sub = op inside {OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG};
    ar_cin = (op inside {OP_ADC, OP_SBC, OP_CPC}) ? status[FL_C] : 1'b0;
    if (op == OP_NEG) begin
      ar_a = '0;
      ar_b = opnd_a;
    end
  end

  alu8_addsub #(.DW(DW)) u_addsub (
    .a(ar_a), .b(ar_b), .cin(ar_cin), .sub(ar_sub),
    .sum(ar_res), .cout(ar_c), .hcarry(ar_h), .ovf(ar_v)
  );

  alu8_unary #(.DW(DW), .SEL_W(SEL_W)) u_unary (
    .op(op), .a(opnd_a), .b(b_sel), .cin(status[FL_C]), .tbit(status[FL_T]),
    .sel(sel), .res(un_res), .cout(un_c), .vout(un_v)
  );

  alu8_flag_next #(.DW(DW), .SEL_W(SEL_W)) u_flags (
    .op(op), .a(opnd_a), .sel(sel), .st(status),
    .ar_res(ar_res), .ar_c(ar_c), .ar_h(ar_h), .ar_v(ar_v),
    .un_res(un_res), .un_c(un_c), .un_v(un_v),
    .result(nx_res), .wb(nx_wb), .nzv_upd(nzv_upd), .st_next(st_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_wb    <= 1'b0;
      status    <= '0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_data  <= nx_res;
      res_wb    <= nx_wb;
      status    <= st_next;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // held output under back-pressure
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_wb)));

  // status moves only when a request is taken
  assert_status_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(status));

  // S tracks N xor V after any N/V update
  assert_sign_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && nzv_upd) |=> (status[FL_S] == (status[FL_N] ^ status[FL_V])));

  // compares never request write-back
  assert_cmp_nowb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op inside {OP_CP, OP_CPC})) |=> !res_wb);

  // chained Z can only stay set or clear
  assert_zchain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op inside {OP_SBC, OP_CPC}) && !status[FL_Z]) |=> !status[FL_Z]);

  // swap leaves every flag alone
  assert_swap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op == OP_SWAP)) |=> (status == $past(status)));

  // complement forces C and clears V
  assert_com_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op == OP_COM)) |=> (status[FL_C] && !status[FL_V]));

  // only flag set/clear may touch I
  assert_ibit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(op inside {OP_FSET, OP_FCLR})) |=> (status[FL_I] == $past(status[FL_I])));
endmodule

// File: tb/alu8_status_test.sv
module alu8_status_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid, op_ready, use_imm, res_valid, res_ready, res_wb;
  logic [4:0] op_code;
  logic [7:0] opnd_a, opnd_b, imm, res_data, status;
  logic [2:0] sel;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] model_st = 8'h00;
  logic [7:0] last_d = 8'h00;
  logic       last_wb = 1'b0;

  always #10 clk = ~clk;

  alu8_status uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm),
    .use_imm(use_imm), .sel(sel), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_wb(res_wb), .status(status)
  );

  // expected {wb, result, status} from the requirement text
  function automatic logic [16:0] ref_model(input int op, input logic [7:0] a,
      input logic [7:0] b, input logic [7:0] st, input logic [2:0] s);
    logic [7:0] r, n;
    logic wb, nzv, zst, c;
    int t, xi, yi, ci;
    n = st; r = a; wb = 1'b1; nzv = 1'b0; zst = 1'b0; c = st[0];
    case (op)
      0, 1: begin
        ci = (op == 1) ? int'(c) : 0;
        t = int'(a) + int'(b) + ci;
        r = t[7:0];
        n[0] = (t > 255);
        n[5] = ((int'(a & 8'h0f) + int'(b & 8'h0f) + ci) > 15);
        n[3] = (a[7] == b[7]) && (r[7] != a[7]);
        nzv = 1'b1;
      end
      2, 3, 4, 5, 6: begin
        xi = (op == 6) ? 0 : int'(a);
        yi = (op == 6) ? int'(a) : int'(b);
        ci = (op == 3 || op == 5) ? int'(c) : 0;
        t = xi - yi - ci;
        r = t[7:0];
        n[0] = (t < 0);
        n[5] = ((xi % 16) - (yi % 16) - ci) < 0;
        n[3] = (xi[7] != yi[7]) && (r[7] != xi[7]);
        nzv = 1'b1;
        zst = (op == 3 || op == 5);
        wb = !(op == 4 || op == 5);
      end
      7:  begin r = a & b; n[3] = 1'b0; nzv = 1'b1; end
      8:  begin r = a | b; n[3] = 1'b0; nzv = 1'b1; end
      9:  begin r = a ^ b; n[3] = 1'b0; nzv = 1'b1; end
      10: begin r = a + 8'd1; n[3] = (r == 8'h80); nzv = 1'b1; end
      11: begin r = a - 8'd1; n[3] = (r == 8'h7f); nzv = 1'b1; end
      12: begin r = ~a; n[0] = 1'b1; n[3] = 1'b0; nzv = 1'b1; end
      13, 14, 15, 16, 17: begin
        case (op)
          13: begin r = {a[6:0], 1'b0}; n[0] = a[7]; end
          14: begin r = {1'b0, a[7:1]}; n[0] = a[0]; end
          15: begin r = {a[6:0], c};    n[0] = a[7]; end
          16: begin r = {c, a[7:1]};    n[0] = a[0]; end
          default: begin r = {a[7], a[7:1]}; n[0] = a[0]; end
        endcase
        n[3] = r[7] ^ n[0];
        nzv = 1'b1;
      end
      18: r = {a[3:0], a[7:4]};
      19: begin n[s] = 1'b1; wb = 1'b0; end
      20: begin n[s] = 1'b0; wb = 1'b0; end
      21: begin n[6] = a[s]; wb = 1'b0; end
      22: r[s] = st[6];
      default: wb = 1'b0;
    endcase
    if (nzv) begin
      n[2] = r[7];
      n[1] = zst ? ((r == 8'h00) && st[1]) : (r == 8'h00);
      n[4] = n[2] ^ n[3];
    end
    return {wb, r, n};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input int op, input logic [7:0] a, input logic [7:0] b,
      input logic imm_on, input logic [7:0] im, input logic [2:0] s, input string req);
    logic [16:0] e;
    op_code = op[4:0]; opnd_a = a; opnd_b = b; use_imm = imm_on; imm = im; sel = s;
    op_valid = 1'b1;
    res_ready = ($urandom % 4) != 0;
    #1;
    while (!op_ready) begin
      chk("R2 held output", {23'd0, res_valid, res_wb, res_data}, {23'd0, 1'b1, last_wb, last_d});
      @(negedge clk);
      res_ready = ($urandom % 2) != 0;
      #1;
    end
    e = ref_model(op, a, imm_on ? im : b, model_st, s);
    @(negedge clk);
    op_valid = 1'b0;
    chk({req, " valid"},  {31'd0, res_valid}, 32'd1);
    chk({req, " result"}, {24'd0, res_data},  {24'd0, e[15:8]});
    chk({req, " wb"},     {31'd0, res_wb},    {31'd0, e[16]});
    chk({req, " status"}, {24'd0, status},    {24'd0, e[7:0]});
    model_st = e[7:0];
    last_d = e[15:8];
    last_wb = e[16];
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL R2 watchdog: got hung run expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0; op_valid = 1'b0; res_ready = 1'b0; op_code = 5'd0;
    opnd_a = 8'd0; opnd_b = 8'd0; imm = 8'd0; use_imm = 1'b0; sel = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 status", {24'd0, status}, 32'd0);
    chk("R1 res_valid", {31'd0, res_valid}, 32'd0);
    chk("R1 op_ready", {31'd0, op_ready}, 32'd1);

    apply(0,  8'h0f, 8'h01, 1'b0, 8'h00, 3'd0, "R3 half carry");
    apply(0,  8'h7f, 8'h01, 1'b0, 8'h00, 3'd0, "R3 signed overflow");
    apply(0,  8'hff, 8'h01, 1'b0, 8'h00, 3'd0, "R3 carry out");
    apply(1,  8'h10, 8'h20, 1'b0, 8'h00, 3'd0, "R3 add with carry");
    apply(0,  8'h99, 8'h99, 1'b1, 8'h22, 3'd0, "R14 immediate");
    apply(2,  8'h10, 8'h01, 1'b0, 8'h00, 3'd0, "R4 nibble borrow");
    apply(2,  8'h80, 8'h01, 1'b0, 8'h00, 3'd0, "R4 overflow");
    apply(4,  8'h05, 8'h05, 1'b0, 8'h00, 3'd0, "R6 compare equal");
    apply(2,  8'h34, 8'h34, 1'b0, 8'h00, 3'd0, "R5 low byte zero");
    apply(3,  8'h12, 8'h12, 1'b0, 8'h00, 3'd0, "R5 chain keeps Z");
    apply(2,  8'h35, 8'h34, 1'b0, 8'h00, 3'd0, "R5 low byte nonzero");
    apply(3,  8'h12, 8'h12, 1'b0, 8'h00, 3'd0, "R5 chain keeps Z clear");
    apply(5,  8'h00, 8'h01, 1'b0, 8'h00, 3'd0, "R6 compare with carry");
    apply(6,  8'h80, 8'h00, 1'b0, 8'h00, 3'd0, "R4 negate 0x80");
    apply(6,  8'h00, 8'h00, 1'b0, 8'h00, 3'd0, "R4 negate zero");
    apply(12, 8'h55, 8'h00, 1'b0, 8'h00, 3'd0, "R8 complement");
    apply(10, 8'h7f, 8'h00, 1'b0, 8'h00, 3'd0, "R7 increment overflow");
    apply(11, 8'h80, 8'h00, 1'b0, 8'h00, 3'd0, "R7 decrement overflow");
    apply(7,  8'hf0, 8'h0f, 1'b0, 8'h00, 3'd0, "R7 and to zero");
    apply(19, 8'h00, 8'h00, 1'b0, 8'h00, 3'd0, "R12 set carry");
    apply(15, 8'h80, 8'h00, 1'b0, 8'h00, 3'd0, "R9 rotate left via carry");
    apply(16, 8'h01, 8'h00, 1'b0, 8'h00, 3'd0, "R9 rotate right via carry");
    apply(17, 8'h81, 8'h00, 1'b0, 8'h00, 3'd0, "R9 arithmetic shift");
    apply(14, 8'h01, 8'h00, 1'b0, 8'h00, 3'd0, "R9 logical right");
    apply(13, 8'h40, 8'h00, 1'b0, 8'h00, 3'd0, "R9 logical left");
    apply(19, 8'h00, 8'h00, 1'b0, 8'h00, 3'd5, "R12 set half carry");
    apply(18, 8'ha5, 8'h00, 1'b0, 8'h00, 3'd0, "R11 swap");
    apply(25, 8'h3c, 8'h00, 1'b0, 8'h00, 3'd0, "R11 unused code");
    apply(21, 8'h08, 8'h00, 1'b0, 8'h00, 3'd3, "R13 bit store");
    apply(22, 8'h00, 8'h00, 1'b0, 8'h00, 3'd5, "R13 bit load");
    apply(19, 8'h00, 8'h00, 1'b0, 8'h00, 3'd7, "R12 set I");
    apply(20, 8'h00, 8'h00, 1'b0, 8'h00, 3'd7, "R12 clear I");

    for (int i = 0; i < 1500; i++) begin
      int op;
      op = (($urandom % 10) == 0) ? int'(23 + ($urandom % 9)) : int'($urandom % 23);
      apply(op, 8'($urandom), 8'($urandom), 1'($urandom), 8'($urandom), 3'($urandom),
            "R10 random");
    end

    res_ready = 1'b1;
    @(negedge clk);
    chk("R2 drained", {31'd0, res_valid}, 32'd0);
    summary();
    $finish;
  end
endmodule